// File: doc/BRIEF.md
# Stack and Index Pointer Unit

This block generates data-memory addresses for stack traffic and indexed loads and stores inside a small 8-bit core in which any register can hold a result. It keeps a 16-bit stack pointer that software loads one byte at a time. It also keeps three 16-bit index pointers, each formed from a pair of high-numbered registers. Each accepted request yields one registered address, one clock later, and updates whichever pointer the request uses in the same clock.

The stack grows toward lower addresses. A push uses the current stack pointer and then steps it down. A pop steps the pointer up first and then uses it. A subroutine call saves a two-byte return address as two pushes on back-to-back cycles, and a return takes it back as two pops in the opposite byte order. Indexed accesses can leave the pointer as it is, step it up after the access, or step it down before the access. Either step changes only the low byte, so an index pointer stays within its 256-byte page. A stack address that falls into the low window reserved for registers and I/O is flagged, and the access still goes ahead.

Top module: `stkidx_unit`

## Requirements
- R1: During and after reset, `sp_value` is 0x045F, all three index pointers read 0x0000, and `addr_valid`, `busy` and `stack_err` are 0.
- R2: `sp_wr_hi` loads `sp_wr_data` into bits 15:8 of the stack pointer and `sp_wr_lo` loads bits 7:0. Each byte is written on its own. When a byte write and a stack step happen in the same cycle, the write decides that byte.
- R3: A push (`req_op`=0) outputs the current stack pointer as `addr`, with `addr_is_write`=1, in the cycle after it is accepted. In that same clock the stack pointer drops by one.
- R4: A pop (`req_op`=1) raises the stack pointer by one and outputs the new value as `addr`, with `addr_is_write`=0, in the cycle after it is accepted.
- R5: A call (`req_op`=2) produces two pushes on consecutive cycles: the first has `addr_hi_byte`=0 and the second has `addr_hi_byte`=1. `busy` is 1 for the cycle after the call is accepted, and any request presented while `busy` is 1 is ignored.
- R6: A return (`req_op`=3) produces two pops on consecutive cycles: the first has `addr_hi_byte`=1 and the second has `addr_hi_byte`=0.
- R7: A register write (`reg_wr_en`) to register number 26, 28 or 30 sets the low byte of index pointer 0, 1 or 2. A write to 27, 29 or 31 sets the matching high byte. A write to any other register number changes no pointer. `ptr_rd_sel` values 0 to 2 read the pointers out; value 3 reads 0.
- R8: An indexed load (`req_op`=4) or store (`req_op`=5) selects its pointer with `req_ptr`. In plain mode (`req_mode`=0, or the unused value 3), the output address equals the pointer and the pointer does not change. `addr_is_write` is 1 only for a store.
- R9: In post-increment mode (`req_mode`=1), the output address is the pointer's value before the step. The low byte is then incremented, wrapping from 0xFF to 0x00, and the high byte does not change.
- R10: In pre-decrement mode (`req_mode`=2), the low byte is first decremented, wrapping from 0x00 to 0xFF, and the output address is the new pointer value. The high byte does not change.
- R11: `stack_err` is 1 together with a stack address (push, pop, call or return) that is below 0x0060, and the access is still carried out. Indexed addresses never raise `stack_err`. Request codes 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sp_wr_hi | input | 1 | Load high byte of the stack pointer |
| sp_wr_lo | input | 1 | Load low byte of the stack pointer |
| sp_wr_data | input | 8 | Byte for stack pointer loads |
| reg_wr_en | input | 1 | Register file write strobe, seen by the pointer bank |
| reg_wr_num | input | 5 | Number of the register being written |
| reg_wr_data | input | 8 | Data of the register write |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 push, 1 pop, 2 call, 3 return, 4 load, 5 store |
| req_ptr | input | 2 | Index pointer used by a load or store |
| req_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement |
| ptr_rd_sel | input | 2 | Index pointer shown on `ptr_rd_value` |
| busy | output | 1 | Second half of a call or return in progress |
| addr_valid | output | 1 | `addr` holds an address this cycle |
| addr | output | 16 | Effective data address |
| addr_is_write | output | 1 | The access is a write (push or store) |
| addr_hi_byte | output | 1 | Return-address byte marker for calls and returns |
| stack_err | output | 1 | Stack address fell inside the reserved window |
| sp_value | output | 16 | Current stack pointer |
| ptr_rd_value | output | 16 | Selected index pointer |

## Verification
On every cycle, the assertions check the push and pop arithmetic as it appears at the ports: the address matches the stack pointer from before the step for a push and from after the step for a pop. They also check that `busy` lasts exactly one cycle after a call, and that `stack_err` only comes with a valid address below the floor. Several behaviours can only be shown by the bench's scenarios: the byte ordering across a call and its matching return, the page wrap of index pointers in both directions, the mapping of register numbers onto pointer bytes, the register writes that must be ignored, and the request dropped while `busy` is set. These scenarios compare each produced address against a queue of expected items.

// File: rtl/stkidx_pkg.sv
// Shared request codes and sequencer states for the stack/index pointer unit.
package stkidx_pkg;

    typedef enum logic [2:0] {
        OP_PUSH  = 3'd0,
        OP_POP   = 3'd1,
        OP_CALL  = 3'd2,
        OP_RET   = 3'd3,
        OP_LOAD  = 3'd4,
        OP_STORE = 3'd5
    } op_e;

    localparam logic [1:0] AM_PLAIN   = 2'd0;
    localparam logic [1:0] AM_POSTINC = 2'd1;
    localparam logic [1:0] AM_PREDEC  = 2'd2;

    typedef enum logic {
        SQ_IDLE,
        SQ_SECOND
    } seq_e;

endpackage

// File: rtl/stkidx_sp.sv
// Stack pointer register.
// Holds a 2*DW bit pointer that software loads one byte at a time. inc/dec
// step the whole pointer; a byte write in the same cycle overrides that byte.
// Assumes inc and dec are never high together (the controller guarantees it).
module stkidx_sp #(
    parameter int DW      = 8,
    parameter int SP_INIT = 'h045F
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_hi,
    input  logic            wr_lo,
    input  logic [DW-1:0]   wdata,
    input  logic            inc,
    input  logic            dec,
    output logic [2*DW-1:0] sp
);
    localparam int AW = 2 * DW;

    logic [AW-1:0] sp_q;
    logic [AW-1:0] sp_nxt;

    // Next value: step first, then let byte writes take their byte.
    always_comb begin
        sp_nxt = sp_q;
        if (inc)
            sp_nxt = sp_q + AW'(1);
        else if (dec)
            sp_nxt = sp_q - AW'(1);
        if (wr_hi)
            sp_nxt[AW-1:DW] = wdata;
        if (wr_lo)
            sp_nxt[DW-1:0] = wdata;
    end

    // State register with synchronous reset to the configured top of stack.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= AW'(SP_INIT);
        else
            sp_q <= sp_nxt;
    end

    assign sp = sp_q;

endmodule

// File: rtl/stkidx_ptrbank.sv
// Index pointer bank.
// NPTR pointers of 2*DW bits, each shadowing a register pair starting at
// register BASE (low byte in the even register). Steps touch only the low
// byte so a pointer wraps inside its page. A register write beats a step.
// Assumes NPTR >= 2 and BASE + 2*NPTR fits in REG_AW bits.
module stkidx_ptrbank #(
    parameter int DW     = 8,
    parameter int NPTR   = 3,
    parameter int REG_AW = 5,
    parameter int BASE   = 26,
    parameter int SELW   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_num,
    input  logic [DW-1:0]     wr_data,
    input  logic              step_en,
    input  logic [SELW-1:0]   step_sel,
    input  logic              step_down,
    input  logic [SELW-1:0]   rd_sel,
    output logic [2*DW-1:0]   rd_val,
    output logic [2*DW-1:0]   step_val
);
    localparam int PW = 2 * DW;

    logic [NPTR*PW-1:0] flat;

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        logic [DW-1:0] lo_q;
        logic [DW-1:0] hi_q;
        logic          hit_lo;
        logic          hit_hi;
        logic          stepped;

        assign hit_lo  = wr_en && (wr_num == REG_AW'(BASE + 2 * g));
        assign hit_hi  = wr_en && (wr_num == REG_AW'(BASE + 2 * g + 1));
        assign stepped = step_en && (step_sel == SELW'(g));

        // Low byte: register write, otherwise in-page step.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lo_q <= '0;
            else if (hit_lo)
                lo_q <= wr_data;
            else if (stepped)
                lo_q <= step_down ? lo_q - DW'(1) : lo_q + DW'(1);
        end

        // High byte: changed only by a register write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                hi_q <= '0;
            else if (hit_hi)
                hi_q <= wr_data;
        end

        assign flat[g*PW +: PW] = {hi_q, lo_q};
    end

    // Read and step-operand multiplexers; unused selects return zero.
    always_comb begin
        rd_val   = '0;
        step_val = '0;
        for (int i = 0; i < NPTR; i++) begin
            if (rd_sel == SELW'(i))
                rd_val = flat[i*PW +: PW];
            if (step_sel == SELW'(i))
                step_val = flat[i*PW +: PW];
        end
    end

endmodule

// File: rtl/stkidx_ctrl.sv
// Request controller and address register.
// Decodes one request per cycle, expands call/return into two stack steps,
// computes the effective address and registers it with its flags.
// Assumes sp and idx_val are the current (pre-update) pointer values.
module stkidx_ctrl
    import stkidx_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 8,
    parameter int SELW        = 2,
    parameter int STACK_FLOOR = 'h0060
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_op,
    input  logic [1:0]      req_mode,
    input  logic [AW-1:0]   sp,
    input  logic [AW-1:0]   idx_val,
    output logic            sp_inc,
    output logic            sp_dec,
    output logic            step_en,
    output logic            step_down,
    output logic            busy,
    output logic            addr_valid,
    output logic [AW-1:0]   addr,
    output logic            addr_is_write,
    output logic            addr_hi_byte,
    output logic            stack_err
);
    seq_e          seq_q, seq_nxt;
    logic          call_q, call_nxt;
    logic          accept;
    logic          go;
    logic          is_stack;
    logic          wr;
    logic          hib;
    logic [AW-1:0] ea;

    assign accept = req_valid && (seq_q == SQ_IDLE);
    assign busy   = (seq_q == SQ_SECOND);

    // Decode: choose address, flags and pointer steps for this cycle.
    always_comb begin
        seq_nxt   = seq_q;
        call_nxt  = call_q;
        go        = 1'b0;
        is_stack  = 1'b0;
        wr        = 1'b0;
        hib       = 1'b0;
        ea        = sp;
        sp_inc    = 1'b0;
        sp_dec    = 1'b0;
        step_en   = 1'b0;
        step_down = 1'b0;
        if (seq_q == SQ_SECOND) begin
            go       = 1'b1;
            is_stack = 1'b1;
            seq_nxt  = SQ_IDLE;
            if (call_q) begin
                ea     = sp;
                sp_dec = 1'b1;
                wr     = 1'b1;
                hib    = 1'b1;
            end else begin
                ea     = sp + AW'(1);
                sp_inc = 1'b1;
            end
        end else if (accept) begin
            case (req_op)
                OP_PUSH, OP_CALL: begin
                    go       = 1'b1;
                    is_stack = 1'b1;
                    ea       = sp;
                    sp_dec   = 1'b1;
                    wr       = 1'b1;
                    if (req_op == OP_CALL) begin
                        seq_nxt  = SQ_SECOND;
                        call_nxt = 1'b1;
                    end
                end
                OP_POP, OP_RET: begin
                    go       = 1'b1;
                    is_stack = 1'b1;
                    ea       = sp + AW'(1);
                    sp_inc   = 1'b1;
                    if (req_op == OP_RET) begin
                        hib      = 1'b1;
                        seq_nxt  = SQ_SECOND;
                        call_nxt = 1'b0;
                    end
                end
                OP_LOAD, OP_STORE: begin
                    go = 1'b1;
                    wr = (req_op == OP_STORE);
                    ea = idx_val;
                    if (req_mode == AM_POSTINC) begin
                        step_en = 1'b1;
                    end else if (req_mode == AM_PREDEC) begin
                        step_en   = 1'b1;
                        step_down = 1'b1;
                        ea        = {idx_val[AW-1:DW], idx_val[DW-1:0] - DW'(1)};
                    end
                end
                default: ;
            endcase
        end
    end

    // Sequencer state for the second half of call/return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q  <= SQ_IDLE;
            call_q <= 1'b0;
        end else begin
            seq_q  <= seq_nxt;
            call_q <= call_nxt;
        end
    end

    // Output register: address, direction, byte marker and window check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid    <= 1'b0;
            addr          <= '0;
            addr_is_write <= 1'b0;
            addr_hi_byte  <= 1'b0;
            stack_err     <= 1'b0;
        end else begin
            addr_valid    <= go;
            addr          <= ea;
            addr_is_write <= wr;
            addr_hi_byte  <= hib;
            stack_err     <= go && is_stack && (ea < AW'(STACK_FLOOR));
        end
    end

endmodule

// File: rtl/stkidx_unit.sv
// Stack and index pointer unit (top).
// Connects the stack pointer, the index pointer bank and the controller.
// Assumes the register file outside mirrors its writes onto reg_wr_*.
module stkidx_unit #(
    parameter int DATA_W       = 8,
    parameter int N_PTR        = 3,
    parameter int PTR_SEL_W    = 2,
    parameter int REG_NUM_W    = 5,
    parameter int PTR_REG_BASE = 26,
    parameter int SP_INIT      = 'h045F,
    parameter int STACK_FLOOR  = 'h0060
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sp_wr_hi,
    input  logic                  sp_wr_lo,
    input  logic [DATA_W-1:0]     sp_wr_data,
    input  logic                  reg_wr_en,
    input  logic [REG_NUM_W-1:0]  reg_wr_num,
    input  logic [DATA_W-1:0]     reg_wr_data,
    input  logic                  req_valid,
    input  logic [2:0]            req_op,
    input  logic [PTR_SEL_W-1:0]  req_ptr,
    input  logic [1:0]            req_mode,
    input  logic [PTR_SEL_W-1:0]  ptr_rd_sel,
    output logic                  busy,
    output logic                  addr_valid,
    output logic [2*DATA_W-1:0]   addr,
    output logic                  addr_is_write,
    output logic                  addr_hi_byte,
    output logic                  stack_err,
    output logic [2*DATA_W-1:0]   sp_value,
    output logic [2*DATA_W-1:0]   ptr_rd_value
);
    localparam int ADDR_W = 2 * DATA_W;

    logic              sp_inc;
    logic              sp_dec;
    logic              step_en;
    logic              step_down;
    logic [ADDR_W-1:0] idx_val;

    stkidx_sp #(
        .DW      (DATA_W),
        .SP_INIT (SP_INIT)
    ) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_hi (sp_wr_hi),
        .wr_lo (sp_wr_lo),
        .wdata (sp_wr_data),
        .inc   (sp_inc),
        .dec   (sp_dec),
        .sp    (sp_value)
    );

    stkidx_ptrbank #(
        .DW     (DATA_W),
        .NPTR   (N_PTR),
        .REG_AW (REG_NUM_W),
        .BASE   (PTR_REG_BASE),
        .SELW   (PTR_SEL_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_num    (reg_wr_num),
        .wr_data   (reg_wr_data),
        .step_en   (step_en),
        .step_sel  (req_ptr),
        .step_down (step_down),
        .rd_sel    (ptr_rd_sel),
        .rd_val    (ptr_rd_value),
        .step_val  (idx_val)
    );

    stkidx_ctrl #(
        .AW          (ADDR_W),
        .DW          (DATA_W),
        .SELW        (PTR_SEL_W),
        .STACK_FLOOR (STACK_FLOOR)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_op        (req_op),
        .req_mode      (req_mode),
        .sp            (sp_value),
        .idx_val       (idx_val),
        .sp_inc        (sp_inc),
        .sp_dec        (sp_dec),
        .step_en       (step_en),
        .step_down     (step_down),
        .busy          (busy),
        .addr_valid    (addr_valid),
        .addr          (addr),
        .addr_is_write (addr_is_write),
        .addr_hi_byte  (addr_hi_byte),
        .stack_err     (stack_err)
    );

endmodule

// File: rtl/stkidx_chk.sv
// Port-level protocol checker for stkidx_unit, attached by bind.
module stkidx_chk #(
    parameter int STACK_FLOOR = 'h0060
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [2:0]  req_op,
    input logic        sp_wr_hi,
    input logic        sp_wr_lo,
    input logic        busy,
    input logic        addr_valid,
    input logic [15:0] addr,
    input logic        addr_is_write,
    input logic        stack_err,
    input logic [15:0] sp_value
);
    logic clean;
    logic push_ok;
    logic pop_ok;
    logic call_ok;

    assign clean   = req_valid && !busy && !sp_wr_hi && !sp_wr_lo;
    assign push_ok = clean && (req_op == 3'd0);
    assign pop_ok  = clean && (req_op == 3'd1);
    assign call_ok = clean && (req_op == 3'd2);

    // R3: push uses the old pointer, then steps it down.
    a_r3_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> addr_valid && addr_is_write && (addr == $past(sp_value))
                    && (sp_value == $past(sp_value) - 16'd1));

    // R4: pop steps the pointer up, then uses the new value.
    a_r4_pop_addr: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ok |=> addr_valid && !addr_is_write
                   && (addr == $past(sp_value) + 16'd1) && (sp_value == addr));

    // R5: a call holds busy for its second push.
    a_r5_call_busy: assert property (@(posedge clk) disable iff (!rst_n)
        call_ok |=> busy);

    // R5: busy never lasts beyond one cycle.
    a_r5_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R11: the window flag only accompanies a valid low address.
    a_r11_err_low: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |-> addr_valid && (addr < 16'(STACK_FLOOR)));

endmodule

bind stkidx_unit stkidx_chk #(.STACK_FLOOR(STACK_FLOOR)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_op        (req_op),
    .sp_wr_hi      (sp_wr_hi),
    .sp_wr_lo      (sp_wr_lo),
    .busy          (busy),
    .addr_valid    (addr_valid),
    .addr          (addr),
    .addr_is_write (addr_is_write),
    .stack_err     (stack_err),
    .sp_value      (sp_value)
);

// File: tb/test_stkidx_unit.sv
// Scoreboard bench: driver tasks queue expected addresses, a monitor
// compares them as the unit produces them.
module test_stkidx_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sp_wr_hi = 1'b0, sp_wr_lo = 1'b0;
    logic [7:0]  sp_wr_data = '0;
    logic        reg_wr_en = 1'b0;
    logic [4:0]  reg_wr_num = '0;
    logic [7:0]  reg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [1:0]  req_ptr = '0;
    logic [1:0]  req_mode = '0;
    logic [1:0]  ptr_rd_sel = '0;
    logic        busy, addr_valid, addr_is_write, addr_hi_byte, stack_err;
    logic [15:0] addr, sp_value, ptr_rd_value;

    stkidx_unit i_stkidx_unit (.*);

    always #10 clk = ~clk;

    typedef struct {
        logic [15:0] a;
        logic        w;
        logic        h;
        logic        e;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          checks = 0;
    int          fails = 0;
    logic [15:0] m_sp = 16'h045F;
    logic [15:0] m_ptr [3] = '{16'h0, 16'h0, 16'h0};

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_item(logic [15:0] a, logic w, logic h, logic e, string tag);
        exp_t it;
        it.a = a; it.w = w; it.h = h; it.e = e; it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compare each produced address with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && addr_valid) begin
            if (q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R5: actual unexpected addr %h expected none", addr);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, " addr"}, {16'h0, addr}, {16'h0, e.a});
                chk({e.tag, " flags"}, {29'h0, addr_is_write, addr_hi_byte, stack_err},
                    {29'h0, e.w, e.h, e.e});
            end
        end
    end

    function automatic logic low_win(logic [15:0] a);
        return a < 16'h0060;
    endfunction

    // Driver: model the request from the requirements, then present it.
    task automatic issue(logic [2:0] op, logic [1:0] p, logic [1:0] mode, string tag);
        @(negedge clk);
        case (op)
            3'd0: begin expect_item(m_sp, 1, 0, low_win(m_sp), tag); m_sp--; end
            3'd1: begin m_sp++; expect_item(m_sp, 0, 0, low_win(m_sp), tag); end
            3'd2: begin
                expect_item(m_sp, 1, 0, low_win(m_sp), tag); m_sp--;
                expect_item(m_sp, 1, 1, low_win(m_sp), tag); m_sp--;
            end
            3'd3: begin
                m_sp++; expect_item(m_sp, 0, 1, low_win(m_sp), tag);
                m_sp++; expect_item(m_sp, 0, 0, low_win(m_sp), tag);
            end
            3'd4, 3'd5: begin
                if (mode == 2'd1) begin
                    expect_item(m_ptr[p], op == 3'd5, 0, 0, tag);
                    m_ptr[p][7:0] = m_ptr[p][7:0] + 8'd1;
                end else if (mode == 2'd2) begin
                    m_ptr[p][7:0] = m_ptr[p][7:0] - 8'd1;
                    expect_item(m_ptr[p], op == 3'd5, 0, 0, tag);
                end else begin
                    expect_item(m_ptr[p], op == 3'd5, 0, 0, tag);
                end
            end
            default: ;
        endcase
        req_valid = 1'b1; req_op = op; req_ptr = p; req_mode = mode;
        @(negedge clk);
        req_valid = 1'b0;
        if (op == 3'd2 || op == 3'd3) @(negedge clk);
    endtask

    task automatic wr_reg(logic [4:0] num, logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_num = num; reg_wr_data = d;
        if (num >= 5'd26) begin
            if (num[0]) m_ptr[(num - 5'd26) >> 1][15:8] = d;
            else        m_ptr[(num - 5'd26) >> 1][7:0]  = d;
        end
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic wr_sp(logic hi, logic [7:0] d);
        @(negedge clk);
        sp_wr_hi = hi; sp_wr_lo = !hi; sp_wr_data = d;
        if (hi) m_sp[15:8] = d; else m_sp[7:0] = d;
        @(negedge clk);
        sp_wr_hi = 1'b0; sp_wr_lo = 1'b0;
    endtask

    task automatic chk_ptr(logic [1:0] sel, logic [15:0] exp, string tag);
        ptr_rd_sel = sel;
        #2;
        chk(tag, {16'h0, ptr_rd_value}, {16'h0, exp});
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state.
        chk("R1 sp", {16'h0, sp_value}, 32'h045F);
        chk("R1 idle", {29'h0, addr_valid, busy, stack_err}, 32'h0);
        chk_ptr(2'd0, 16'h0, "R1 ptr0");
        chk_ptr(2'd2, 16'h0, "R1 ptr2");
        rst_n = 1'b1;

        // R2: independent byte loads.
        wr_sp(1'b1, 8'h02);
        wr_sp(1'b0, 8'h10);
        chk("R2 sp both", {16'h0, sp_value}, {16'h0, m_sp});
        wr_sp(1'b0, 8'h80);
        chk("R2 sp low only", {16'h0, sp_value}, 32'h0280);

        // R2: byte write wins over the push step for that byte.
        @(negedge clk);
        expect_item(m_sp, 1, 0, 0, "R2 push+write");
        m_sp = {8'h02, 8'h40};
        req_valid = 1'b1; req_op = 3'd0; sp_wr_lo = 1'b1; sp_wr_data = 8'h40;
        @(negedge clk);
        req_valid = 1'b0; sp_wr_lo = 1'b0;
        chk("R2 write wins", {16'h0, sp_value}, 32'h0240);

        // R3, R4: pushes and pops.
        issue(3'd0, 0, 0, "R3 push");
        issue(3'd0, 0, 0, "R3 push");
        chk("R3 sp after", {16'h0, sp_value}, 32'h023E);
        issue(3'd1, 0, 0, "R4 pop");
        issue(3'd1, 0, 0, "R4 pop");
        chk("R4 sp after", {16'h0, sp_value}, 32'h0240);

        // R5, R6: call then return.
        issue(3'd2, 0, 0, "R5 call");
        chk("R5 sp after call", {16'h0, sp_value}, 32'h023E);
        issue(3'd3, 0, 0, "R6 ret");
        chk("R6 sp after ret", {16'h0, sp_value}, 32'h0240);

        // R5: a push presented while busy is dropped.
        @(negedge clk);
        expect_item(m_sp, 1, 0, 0, "R5 busy call"); m_sp--;
        expect_item(m_sp, 1, 1, 0, "R5 busy call"); m_sp--;
        req_valid = 1'b1; req_op = 3'd2;
        @(negedge clk);
        chk("R5 busy", {31'h0, busy}, 32'h1);
        req_op = 3'd0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R5 push ignored", {16'h0, sp_value}, 32'h023E);

        // R11: reserved window flag, access still performed.
        wr_sp(1'b1, 8'h00);
        wr_sp(1'b0, 8'h61);
        issue(3'd0, 0, 0, "R11 push");
        issue(3'd0, 0, 0, "R11 push");
        issue(3'd0, 0, 0, "R11 push low");
        chk("R11 sp low", {16'h0, sp_value}, 32'h005E);
        issue(3'd1, 0, 0, "R11 pop low");
        issue(3'd1, 0, 0, "R11 pop");
        issue(3'd1, 0, 0, "R11 pop");
        issue(3'd6, 0, 0, "R11 code 6");
        chk("R11 code 6 ignored", {16'h0, sp_value}, 32'h0061);

        // R7: register pair mapping and ignored registers.
        wr_reg(5'd26, 8'hFF);
        wr_reg(5'd27, 8'h12);
        wr_reg(5'd28, 8'h10);
        wr_reg(5'd31, 8'h34);
        wr_reg(5'd25, 8'hAA);
        wr_reg(5'd0, 8'h55);
        chk_ptr(2'd0, 16'h12FF, "R7 ptr0");
        chk_ptr(2'd1, 16'h0010, "R7 ptr1");
        chk_ptr(2'd2, 16'h3400, "R7 ptr2");
        chk_ptr(2'd3, 16'h0000, "R7 sel3");

        // R8: plain mode, and mode 3 behaves as plain.
        issue(3'd4, 2'd1, 2'd0, "R8 plain load");
        issue(3'd5, 2'd1, 2'd3, "R8 mode3 store");
        chk_ptr(2'd1, 16'h0010, "R8 ptr1 unchanged");

        // R9: post-increment wraps within the page.
        issue(3'd4, 2'd0, 2'd1, "R9 postinc");
        chk_ptr(2'd0, 16'h1200, "R9 ptr0 wrap");
        issue(3'd5, 2'd0, 2'd1, "R9 postinc store");
        chk_ptr(2'd0, 16'h1201, "R9 ptr0 step");

        // R10: pre-decrement wraps within the page.
        issue(3'd5, 2'd2, 2'd2, "R10 predec");
        chk_ptr(2'd2, 16'h34FF, "R10 ptr2 wrap");
        issue(3'd4, 2'd2, 2'd2, "R10 predec load");
        chk_ptr(2'd2, 16'h34FE, "R10 ptr2 step");

        repeat (4) @(negedge clk);
        chk("R5 queue drained", q.size(), 0);
        summary();
    end

endmodule